// File: doc/BRIEF.md
# Framebuffer Scanout Engine

This block streams a stored picture from an on-chip pixel buffer to a display. A timing controller counts pixel clocks across each line and lines across each frame. From those counts it produces horizontal and vertical sync and the blanking window. It also hands the read engine two strobes: a fetch strobe on every visible pixel and a restart strobe once per frame. The read engine walks the buffer from word zero upward, one word per visible pixel. The address is not computed from x/y coordinates. It moves only when the timing controller says so, holds through every retrace interval, and returns to zero when a frame ends.

The buffer has a one-clock read latency. The sync and blanking flags are registered in the same clock as the buffer read, so the pixel word and its valid strobe reach the ports together. A separate write port lets a host update buffer words at any time. Buffer addresses take the low `BUF_AW` bits of the scan address. The default timing is the common 640x480 mode: 800 clocks per line and 525 lines per frame, which gives about 60 Hz from a 25 MHz pixel clock.

Top module: `fb_scanout`

## Requirements
- R1: A line lasts H_ACTIVE+H_FRONT+H_SYNC+H_BACK clocks, and a frame lasts V_ACTIVE+V_FRONT+V_SYNC+V_BACK lines. Each line runs in this order: the visible pixels, then the front porch, then sync, then the back porch. Each frame runs in the same order, counted in lines. The defaults give 800 clocks and 525 lines.
- R2: `hSyncOut` is asserted for H_SYNC clocks. Assertion begins H_ACTIVE+H_FRONT clocks after the line starts. The asserted level is 1 when HSYNC_HIGH=1 and 0 when HSYNC_HIGH=0. The default is 0.
- R3: `vSyncOut` is asserted for V_SYNC whole lines. Assertion begins V_ACTIVE+V_FRONT lines after the frame starts. The asserted level is 1 when VSYNC_HIGH=1 and 0 when VSYNC_HIGH=0. The default is 0.
- R4: `pixValid` is 1 and `blankOut` is 0 only on the first H_ACTIVE clocks of each of the first V_ACTIVE lines. On the clock after reset is released, the outputs show line 0, pixel 0.
- R5: The buffer is read strictly in sequence, one word per visible pixel, and each word is read exactly once per frame.
- R6: The read address holds through horizontal and vertical retrace. The first pixel of line n therefore shows word n*H_ACTIVE.
- R7: At the start of every frame the read address returns to 0. The first pixel of each frame therefore shows word 0.
- R8: While `pixValid` is 0, `pixData` is driven to zero.
- R9: While `rst` is high at a clock edge, the block does the following: `pixValid` is 0, `pixData` is 0, both syncs are at their inactive level, the counters go to line 0, pixel 0, and the read address goes to 0. This holds even when reset arrives in mid-frame.
- R10: A clock edge with `wrEn` high stores `wrData` at `wrAddr`, independently of the scan. The new value appears the next time the scan reaches that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Buffer write enable |
| wrAddr | input | BUF_AW | Buffer write address |
| wrData | input | PIX_W | Buffer write data |
| hSyncOut | output | 1 | Horizontal sync, polarity set by HSYNC_HIGH |
| vSyncOut | output | 1 | Vertical sync, polarity set by VSYNC_HIGH |
| blankOut | output | 1 | High outside the visible window |
| pixValid | output | 1 | High on visible pixels |
| pixData | output | PIX_W | Pixel value, zero while blanked |

## Verification
The hardest condition to reach from the ports is an address that must survive retrace. A fault that lets the address creep during blanking, or forget to restart, still shows plausible pixels. The bench fills the buffer with a pattern that is unique per word and shrinks the timing parameters so that a whole frame spans about a hundred clocks. It then compares every output on every clock of two full frames against a position model. Any drift shows up at the first pixel of the next line or frame. A reset in mid-frame and a write into a word that is about to be scanned cover the two remaining cases.

// File: rtl/scan_pkg.sv
package scan_pkg;
  // Strobes from the timing controller to the read engine
  typedef struct packed {
    logic fetch;    // visible pixel: read a word and advance the address
    logic restart;  // last clock of the frame: return the address to zero
  } scanStrb_t;
endpackage

// File: rtl/scan_pixel_buf.sv
module scan_pixel_buf #(
  parameter int PIX_W  = 8,
  parameter int BUF_AW = 12
) (
  input  logic              clk,
  input  logic              wrEn,
  input  logic [BUF_AW-1:0] wrAddr,
  input  logic [PIX_W-1:0]  wrData,
  input  logic              rdEn,
  input  logic [BUF_AW-1:0] rdAddr,
  output logic [PIX_W-1:0]  rdData
);
  localparam int DEPTH = 1 << BUF_AW;

  logic [PIX_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn) store[wrAddr] <= wrData;
  end

  // One-clock read latency; the register doubles as the prefetch entry
  always_ff @(posedge clk) begin
    if (rdEn) rdData <= store[rdAddr];
  end
endmodule

// File: rtl/scan_timing.sv
module scan_timing
  import scan_pkg::*;
#(
  parameter int H_ACTIVE   = 640,
  parameter int H_FRONT    = 16,
  parameter int H_SYNC     = 96,
  parameter int H_BACK     = 48,
  parameter int V_ACTIVE   = 480,
  parameter int V_FRONT    = 10,
  parameter int V_SYNC     = 2,
  parameter int V_BACK     = 33,
  parameter bit HSYNC_HIGH = 1'b0,
  parameter bit VSYNC_HIGH = 1'b0
) (
  input  logic      clk,
  input  logic      rst,
  output scanStrb_t strb,
  output logic      hSyncQ,
  output logic      vSyncQ,
  output logic      activeQ
);
  localparam int H_TOTAL = H_ACTIVE + H_FRONT + H_SYNC + H_BACK;
  localparam int V_TOTAL = V_ACTIVE + V_FRONT + V_SYNC + V_BACK;
  localparam int HW = $clog2(H_TOTAL);
  localparam int VW = $clog2(V_TOTAL);
  localparam logic [HW-1:0] H_LAST   = HW'(H_TOTAL - 1);
  localparam logic [VW-1:0] V_LAST   = VW'(V_TOTAL - 1);
  localparam logic [HW-1:0] H_VIS    = HW'(H_ACTIVE);
  localparam logic [VW-1:0] V_VIS    = VW'(V_ACTIVE);
  localparam logic [HW-1:0] H_SSTART = HW'(H_ACTIVE + H_FRONT);
  localparam logic [HW-1:0] H_SEND   = HW'(H_ACTIVE + H_FRONT + H_SYNC);
  localparam logic [VW-1:0] V_SSTART = VW'(V_ACTIVE + V_FRONT);
  localparam logic [VW-1:0] V_SEND   = VW'(V_ACTIVE + V_FRONT + V_SYNC);

  logic [HW-1:0] hCnt;
  logic [VW-1:0] vCnt;
  logic          visNow;
  logic          hInSync;
  logic          vInSync;

  always_ff @(posedge clk) begin
    if (rst) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (hCnt == H_LAST) begin
      hCnt <= '0;
      vCnt <= (vCnt == V_LAST) ? '0 : vCnt + 1'b1;
    end else begin
      hCnt <= hCnt + 1'b1;
    end
  end

  always_comb begin
    visNow       = (hCnt < H_VIS) && (vCnt < V_VIS);
    hInSync      = (hCnt >= H_SSTART) && (hCnt < H_SEND);
    vInSync      = (vCnt >= V_SSTART) && (vCnt < V_SEND);
    strb.fetch   = visNow && !rst;
    strb.restart = !rst && (hCnt == H_LAST) && (vCnt == V_LAST);
  end

  // Registered in step with the buffer read so flags and data line up
  always_ff @(posedge clk) begin
    if (rst) begin
      hSyncQ  <= ~HSYNC_HIGH;
      vSyncQ  <= ~VSYNC_HIGH;
      activeQ <= 1'b0;
    end else begin
      hSyncQ  <= hInSync ? HSYNC_HIGH : ~HSYNC_HIGH;
      vSyncQ  <= vInSync ? VSYNC_HIGH : ~VSYNC_HIGH;
      activeQ <= visNow;
    end
  end

  AST_H_WRAP: assert property (@(posedge clk) disable iff (rst)
    (hCnt == H_LAST) |=> (hCnt == '0)); // R1
  AST_V_HOLD: assert property (@(posedge clk) disable iff (rst)
    (hCnt != H_LAST) |=> $stable(vCnt)); // R1
  AST_HSYNC_OFF_VISIBLE: assert property (@(posedge clk) disable iff (rst)
    activeQ |-> (hSyncQ != HSYNC_HIGH)); // R2
  AST_VSYNC_OFF_VISIBLE: assert property (@(posedge clk) disable iff (rst)
    activeQ |-> (vSyncQ != VSYNC_HIGH)); // R3
endmodule

// File: rtl/scan_datapath.sv
module scan_datapath
  import scan_pkg::*;
#(
  parameter int PIX_W     = 8,
  parameter int BUF_AW    = 12,
  parameter int FRAME_PIX = 640 * 480
) (
  input  logic              clk,
  input  logic              rst,
  input  scanStrb_t         strb,
  input  logic              lineActive,
  input  logic              wrEn,
  input  logic [BUF_AW-1:0] wrAddr,
  input  logic [PIX_W-1:0]  wrData,
  output logic [PIX_W-1:0]  pixOut
);
  localparam int ADDR_W = $clog2(FRAME_PIX + 1);
  localparam logic [ADDR_W-1:0] FRAME_END = ADDR_W'(FRAME_PIX);

  logic [ADDR_W-1:0] addr;
  logic [BUF_AW-1:0] rdAddr;
  logic [PIX_W-1:0]  rdData;

  always_ff @(posedge clk) begin
    if (rst || strb.restart) addr <= '0;
    else if (strb.fetch)     addr <= addr + 1'b1;
  end

  generate
    if (ADDR_W >= BUF_AW) begin : g_trim
      assign rdAddr = addr[BUF_AW-1:0];
    end else begin : g_pad
      assign rdAddr = {{(BUF_AW - ADDR_W){1'b0}}, addr};
    end
  endgenerate

  scan_pixel_buf #(.PIX_W(PIX_W), .BUF_AW(BUF_AW)) u_buf (
    .clk    (clk),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .rdEn   (strb.fetch),
    .rdAddr (rdAddr),
    .rdData (rdData)
  );

  assign pixOut = lineActive ? rdData : '0;

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    strb.fetch |=> (addr == ADDR_W'($past(addr) + 1'b1))); // R5
  AST_FRAME_COUNT: assert property (@(posedge clk) disable iff (rst)
    strb.restart |-> (addr == FRAME_END)); // R5
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!strb.fetch && !strb.restart) |=> $stable(addr)); // R6
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst)
    strb.restart |=> (addr == '0)); // R7
endmodule

// File: rtl/fb_scanout.sv
module fb_scanout
  import scan_pkg::*;
#(
  parameter int H_ACTIVE   = 640,
  parameter int H_FRONT    = 16,
  parameter int H_SYNC     = 96,
  parameter int H_BACK     = 48,
  parameter int V_ACTIVE   = 480,
  parameter int V_FRONT    = 10,
  parameter int V_SYNC     = 2,
  parameter int V_BACK     = 33,
  parameter bit HSYNC_HIGH = 1'b0,
  parameter bit VSYNC_HIGH = 1'b0,
  parameter int PIX_W      = 8,
  parameter int BUF_AW     = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [BUF_AW-1:0] wrAddr,
  input  logic [PIX_W-1:0]  wrData,
  output logic              hSyncOut,
  output logic              vSyncOut,
  output logic              blankOut,
  output logic              pixValid,
  output logic [PIX_W-1:0]  pixData
);
  localparam int FRAME_PIX = H_ACTIVE * V_ACTIVE;

  scanStrb_t strb;
  logic      activeQ;

  scan_timing #(
    .H_ACTIVE(H_ACTIVE), .H_FRONT(H_FRONT), .H_SYNC(H_SYNC), .H_BACK(H_BACK),
    .V_ACTIVE(V_ACTIVE), .V_FRONT(V_FRONT), .V_SYNC(V_SYNC), .V_BACK(V_BACK),
    .HSYNC_HIGH(HSYNC_HIGH), .VSYNC_HIGH(VSYNC_HIGH)
  ) u_timing (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .hSyncQ  (hSyncOut),
    .vSyncQ  (vSyncOut),
    .activeQ (activeQ)
  );

  scan_datapath #(
    .PIX_W(PIX_W), .BUF_AW(BUF_AW), .FRAME_PIX(FRAME_PIX)
  ) u_data (
    .clk        (clk),
    .rst        (rst),
    .strb       (strb),
    .lineActive (activeQ),
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .pixOut     (pixData)
  );

  assign pixValid = activeQ;
  assign blankOut = ~activeQ;
endmodule

// File: tb/sim_fb_scanout.sv
module sim_fb_scanout;
  localparam int HA = 6, HF = 2, HS = 3, HB = 2;
  localparam int VA = 4, VF = 1, VS = 2, VB = 1;
  localparam int HT = HA + HF + HS + HB;   // 13
  localparam int VT = VA + VF + VS + VB;   // 8
  localparam int FT = HT * VT;             // 104
  localparam int PW = 8, AW = 5;
  localparam int NV = 14;
  // {position, valid, hsync asserted, vsync asserted}
  localparam logic [18:0] VEC [NV] = '{
    {16'd0,   1'b1, 1'b0, 1'b0},
    {16'd5,   1'b1, 1'b0, 1'b0},
    {16'd6,   1'b0, 1'b0, 1'b0},
    {16'd8,   1'b0, 1'b1, 1'b0},
    {16'd10,  1'b0, 1'b1, 1'b0},
    {16'd11,  1'b0, 1'b0, 1'b0},
    {16'd12,  1'b0, 1'b0, 1'b0},
    {16'd13,  1'b1, 1'b0, 1'b0},
    {16'd52,  1'b0, 1'b0, 1'b0},
    {16'd65,  1'b0, 1'b0, 1'b1},
    {16'd73,  1'b0, 1'b1, 1'b1},
    {16'd91,  1'b0, 1'b0, 1'b0},
    {16'd103, 1'b0, 1'b0, 1'b0},
    {16'd104, 1'b1, 1'b0, 1'b0}
  };

  logic clk = 1'b0, rst = 1'b1, wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [PW-1:0] wrData = '0;
  logic hSyncOut, vSyncOut, blankOut, pixValid;
  logic [PW-1:0] pixData;
  int checks = 0, errors = 0, pos = -1;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fb_scanout #(
    .H_ACTIVE(HA), .H_FRONT(HF), .H_SYNC(HS), .H_BACK(HB),
    .V_ACTIVE(VA), .V_FRONT(VF), .V_SYNC(VS), .V_BACK(VB),
    .HSYNC_HIGH(1'b0), .VSYNC_HIGH(1'b1), .PIX_W(PW), .BUF_AW(AW)
  ) u0 (.*);

  function automatic logic [PW-1:0] pat(int a);
    return PW'(a * 37 + 11);
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s pos=%0d actual=%0d expected=%0d", tag, pos, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
    pos++;
  endtask

  initial begin
    int ti = 0;
    tick();
    // R9: reset state
    chk("R9 valid", pixValid, 0);
    chk("R9 blank", blankOut, 1);
    chk("R9 data", pixData, 0);
    chk("R9 hsync", hSyncOut, 1);
    chk("R9 vsync", vSyncOut, 0);
    for (int a = 0; a < HA * VA; a++) begin
      wrEn = 1'b1; wrAddr = AW'(a); wrData = pat(a);
      tick();
    end
    wrEn = 1'b0; rst = 1'b0; pos = -1;
    // Two full frames against the position model
    for (int i = 0; i < 2 * FT; i++) begin
      int h, v, ev, ep;
      tick();
      h = pos % HT; v = (pos / HT) % VT;
      ev = (h < HA && v < VA) ? 1 : 0;
      ep = ev ? int'(pat(v * HA + h)) : 0;
      chk("R4 valid", pixValid, ev);
      chk("R4 blank", blankOut, 1 - ev);
      if (!ev) chk("R8 zero while blank", pixData, 0);
      else if (h == 0 && v == 0) chk("R7 frame restart", pixData, ep);
      else if (h == 0) chk("R6 hold over retrace", pixData, ep);
      else chk("R5 sequential", pixData, ep);
      chk("R2 hsync", hSyncOut, (h >= HA + HF && h < HA + HF + HS) ? 0 : 1);
      chk("R3 vsync", vSyncOut, (v >= VA + VF && v < VA + VF + VS) ? 1 : 0);
      if (ti < NV && int'(VEC[ti][18:3]) == pos) begin
        chk("R1 table valid", pixValid, VEC[ti][2]);
        chk("R1 table hsync", hSyncOut, VEC[ti][1] ? 0 : 1);
        chk("R1 table vsync", vSyncOut, VEC[ti][0] ? 1 : 0);
        ti++;
      end
    end
    chk("R1 table walked", ti, NV);
    // R10: write word 2 just before the next frame scans it
    wrEn = 1'b1; wrAddr = AW'(2); wrData = 8'h5A;
    tick();
    wrEn = 1'b0;
    chk("R7 word0 next frame", pixData, pat(0));
    tick();
    chk("R5 word1 next frame", pixData, pat(1));
    tick();
    chk("R10 written word shown", pixData, 8'h5A);
    while (pos < 2 * FT + 30) tick();
    // R9: reset in mid-frame
    rst = 1'b1;
    tick();
    chk("R9 mid reset valid", pixValid, 0);
    chk("R9 mid reset data", pixData, 0);
    chk("R9 mid reset hsync", hSyncOut, 1);
    tick();
    rst = 1'b0; pos = -1;
    tick();
    chk("R9 restart word0", pixData, pat(0));
    chk("R4 first after reset valid", pixValid, 1);
    tick();
    chk("R9 restart word1", pixData, pat(1));
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired at pos=%0d", pos);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule